// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block predicts the direction of conditional branches for a short in-order pipeline. During fetch, the low-order bits of the program counter select one entry of a direct-mapped table. Each entry is a two-bit saturating counter, and its upper bit is the taken/not-taken guess. Two branches that share those index bits share one entry. This costs some accuracy but never affects correctness.

The guess is registered into a one-entry slot that sits beside the fetch/decode pipeline register. It follows the instruction into decode. Once decode knows that the instruction is a branch and knows its real outcome, the block compares the two. It moves the counter one step toward the outcome. On a disagreement it raises a mispredict flag and clears the slot, so the instruction fetched behind the branch is treated as a bubble while fetch is steered to the right address elsewhere.

When decode is stalled, the slot keeps its contents, and the counter is written only once, on the cycle the branch leaves decode. Every entry takes the same selectable starting state at reset. The reset input is asserted asynchronously and released on a clock edge by an internal two-flop stage. The byte-offset width `OFS_W` must be at least 1, and `PC_W` must exceed `OFS_W + IDX_W`.

Top module: `bht2_predictor`

## Requirements
- R1: While reset is asserted and after it is released, every entry holds the `INIT_STATE` counter value, so `fetch_pred` equals bit 1 of `INIT_STATE` for any index.
- R2: The entry index is `fetch_pc[OFS_W +: IDX_W]`. Addresses that differ only in offset bits or in bits above the index read and train the same entry.
- R3: `fetch_pred` is bit 1 of the addressed counter. The counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken.
- R4: A resolved taken branch increments its counter and saturates at 11. A resolved not-taken branch decrements it and saturates at 00.
- R5: Starting from a strong state, the predicted direction flips only after two consecutive outcomes against it.
- R6: One cycle after a fetch with `fetch_valid` high and `ifid_hold` low, `dec_valid` is 1 and `dec_pred` equals the `fetch_pred` value of that fetch cycle.
- R7: `dec_mispredict` is high in the same cycle exactly when `dec_valid`, `dec_is_branch` and not `ifid_hold` all hold and `dec_pred` differs from `dec_taken`.
- R8: In the cycle after `dec_mispredict`, `dec_valid` is 0 even if `fetch_valid` was high, so the wrongly fetched instruction neither updates the table nor reports a mispredict.
- R9: While `ifid_hold` is high, `dec_valid` and `dec_pred` keep their values. No mispredict is reported, no counter changes, and the fetch input is ignored.
- R10: A valid decode slot with `dec_is_branch` low leaves the table unchanged, whatever `dec_taken` is.
- R11: When a fetch and an update address the same entry in the same cycle, `fetch_pred` shows the counter value from before the update.
- R12: For a loop-closing branch that is taken nine times and then not taken, repeated, the steady state is exactly one mispredict per ten executions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| fetch_valid | input | 1 | An instruction is being fetched this cycle |
| fetch_pc | input | PC_W | Fetch address |
| fetch_pred | output | 1 | Direction guess for the fetch address (1 = taken) |
| ifid_hold | input | 1 | Decode stall: the fetch/decode register keeps its contents |
| dec_is_branch | input | 1 | The instruction in decode is a conditional branch |
| dec_taken | input | 1 | Real outcome of the branch in decode |
| dec_valid | output | 1 | The decode slot carries a fetched instruction |
| dec_pred | output | 1 | Guess carried with the instruction in decode |
| dec_mispredict | output | 1 | Carried guess was wrong; flush fetch and redirect |

## Verification
The bench builds the block with `IDX_W = 4`, `OFS_W = 2`, `PC_W = 16` and `INIT_STATE = 2'b01`. The sixteen-entry table lets the reset check visit every entry. It also makes aliasing easy to reach, because two addresses that differ only above bit 5 land on the same counter. The weak not-taken start means a single taken outcome already flips the guess, while saturation and two-step hysteresis need only a few more branches. The bench keeps its own counter model per entry and checks every guess, mispredict and flush against it, including during stalls and same-entry read/update collisions.

// File: rtl/bht_pkg.sv
package bht_pkg;

  // Two-bit saturating direction counter; bit 1 is the guess.
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  function automatic ctr_t ctr_step(ctr_t cur, logic taken);
    ctr_t nxt;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_guess(ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bht_rst_sync.sv
module bht_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/bht_entry.sv
module bht_entry
  import bht_pkg::*;
#(
  parameter ctr_t INIT = CTR_WNT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic taken,
  output ctr_t state
);
  ctr_t state_q;
  ctr_t state_d;

  always_comb begin
    state_d = ctr_step(state_q, taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= INIT;
    else if (wr_en) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int   IDX_W = 11,
  parameter ctr_t INIT  = CTR_WNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_state,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t             states [ENTRIES];
  logic [ENTRIES-1:0] wr_sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign wr_sel[g] = upd_en && (upd_idx == IDX_W'(g));

    bht_entry #(.INIT(INIT)) u_entry (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_sel[g]),
      .taken (upd_taken),
      .state (states[g])
    );
  end

  // Read sees the register value, i.e. the state before any same-cycle write.
  assign rd_state = states[rd_idx];
endmodule

// File: rtl/bht_ifid_slot.sv
module bht_ifid_slot #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             in_pred,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  output logic             out_pred,
  output logic [IDX_W-1:0] out_idx
);
  logic             valid_q, valid_d;
  logic             pred_q,  pred_d;
  logic [IDX_W-1:0] idx_q,   idx_d;

  always_comb begin
    valid_d = in_valid && !flush;
    pred_d  = in_pred;
    idx_d   = in_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pred_q  <= 1'b0;
      idx_q   <= '0;
    end else if (load_en) begin
      valid_q <= valid_d;
      pred_q  <= pred_d;
      idx_q   <= idx_d;
    end
  end

  assign out_valid = valid_q;
  assign out_pred  = pred_q;
  assign out_idx   = idx_q;
endmodule

// File: rtl/bht2_predictor.sv
module bht2_predictor
  import bht_pkg::*;
#(
  parameter int         PC_W       = 32,
  parameter int         OFS_W      = 2,
  parameter int         IDX_W      = 11,
  parameter logic [1:0] INIT_STATE = 2'b01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_pred,
  input  logic            ifid_hold,
  input  logic            dec_is_branch,
  input  logic            dec_taken,
  output logic            dec_valid,
  output logic            dec_pred,
  output logic            dec_mispredict
);
  localparam int   IDX_LO = OFS_W;
  localparam int   IDX_HI = OFS_W + IDX_W;
  localparam ctr_t INIT   = ctr_t'(INIT_STATE);

  logic             rst_core_n;
  logic [IDX_W-1:0] fetch_idx;
  ctr_t             rd_state;
  logic             advance;
  logic             upd_en;
  logic             slot_valid;
  logic             slot_pred;
  logic [IDX_W-1:0] slot_idx;
  logic             unused_pc_bits;

  bht_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign fetch_idx      = fetch_pc[IDX_LO +: IDX_W];
  assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_HI], fetch_pc[OFS_W-1:0]};

  bht_table #(.IDX_W(IDX_W), .INIT(INIT)) u_table (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rd_idx    (fetch_idx),
    .rd_state  (rd_state),
    .upd_en    (upd_en),
    .upd_idx   (slot_idx),
    .upd_taken (dec_taken)
  );

  assign fetch_pred = ctr_guess(rd_state);

  // Decode resolves only on the cycle the branch leaves decode.
  assign advance        = !ifid_hold;
  assign upd_en         = slot_valid && dec_is_branch && advance;
  assign dec_mispredict = upd_en && (slot_pred != dec_taken);

  bht_ifid_slot #(.IDX_W(IDX_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_en   (advance),
    .flush     (dec_mispredict),
    .in_valid  (fetch_valid),
    .in_pred   (fetch_pred),
    .in_idx    (fetch_idx),
    .out_valid (slot_valid),
    .out_pred  (slot_pred),
    .out_idx   (slot_idx)
  );

  assign dec_valid = slot_valid;
  assign dec_pred  = slot_pred;
endmodule

// File: rtl/bht2_predictor_chk.sv
module bht2_predictor_chk (
  input logic clk,
  input logic rst_n,
  input logic fetch_valid,
  input logic fetch_pred,
  input logic ifid_hold,
  input logic dec_is_branch,
  input logic dec_taken,
  input logic dec_valid,
  input logic dec_pred,
  input logic dec_mispredict
);
  // R7: a mispredict needs a valid, advancing branch whose guess was wrong
  p_mp_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_mispredict |-> (dec_valid && dec_is_branch && !ifid_hold && (dec_pred != dec_taken)));

  // R7: a wrong guess on an advancing valid branch is always reported
  p_mp_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_is_branch && !ifid_hold && (dec_pred != dec_taken)) |-> dec_mispredict);

  // R8: the slot behind a mispredict is a bubble
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_mispredict |=> !dec_valid);

  // R9: a stall freezes the slot
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold |=> ($stable(dec_valid) && $stable(dec_pred)));

  // R6: the guess travels unchanged into decode
  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ifid_hold && !dec_mispredict && fetch_valid) |=> (dec_valid && (dec_pred == $past(fetch_pred))));
endmodule

bind bht2_predictor bht2_predictor_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_valid    (fetch_valid),
  .fetch_pred     (fetch_pred),
  .ifid_hold      (ifid_hold),
  .dec_is_branch  (dec_is_branch),
  .dec_taken      (dec_taken),
  .dec_valid      (dec_valid),
  .dec_pred       (dec_pred),
  .dec_mispredict (dec_mispredict)
);

// File: tb/sim_bht2_predictor.sv
`timescale 1ns/1ps
module sim_bht2_predictor;
  localparam int PC_W = 16;
  localparam int OFS_W = 2;
  localparam int IDX_W = 4;
  localparam int ENT = 1 << IDX_W;
  localparam logic [1:0] INIT = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic ifid_hold = 1'b0;
  logic dec_is_branch = 1'b0;
  logic dec_taken = 1'b0;
  logic fetch_pred, dec_valid, dec_pred, dec_mispredict;

  int n_checks = 0;
  int n_fail = 0;
  logic [1:0] mdl [ENT];

  always #10 clk = ~clk;

  bht2_predictor #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .INIT_STATE(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_pred(fetch_pred), .ifid_hold(ifid_hold), .dec_is_branch(dec_is_branch),
    .dec_taken(dec_taken), .dec_valid(dec_valid), .dec_pred(dec_pred),
    .dec_mispredict(dec_mispredict)
  );

  function automatic logic [1:0] step(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[OFS_W +: IDX_W]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_drive();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fetch_valid = 0; dec_is_branch = 0; ifid_hold = 0; dec_taken = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    for (int i = 0; i < ENT; i++) mdl[i] = INIT;
  endtask

  // Fetch pc, then resolve it in decode with outcome t. Returns mispredict seen.
  task automatic do_branch(input logic [PC_W-1:0] pc, input logic t, output logic mp);
    int k = idx_of(pc);
    logic exp_p = mdl[k][1];
    fetch_pc = pc; fetch_valid = 1; dec_is_branch = 0;
    @(negedge clk);
    chk(fetch_pred == exp_p, "R3", fetch_pred, exp_p);
    edge_drive();
    fetch_valid = 0; dec_is_branch = 1; dec_taken = t;
    @(negedge clk);
    chk(dec_valid && dec_pred == exp_p, "R6", dec_pred, exp_p);
    chk(dec_mispredict == (exp_p != t), "R7", dec_mispredict, exp_p != t);
    mp = dec_mispredict;
    mdl[k] = step(mdl[k], t);
    edge_drive();
    dec_is_branch = 0;
  endtask

  task automatic peek(input logic [PC_W-1:0] pc, input logic exp, input string req);
    fetch_pc = pc; fetch_valid = 0;
    @(negedge clk);
    chk(fetch_pred == exp, req, fetch_pred, exp);
    edge_drive();
  endtask

  task automatic t_reset_r1();
    chk(dec_valid == 0, "R1", dec_valid, 0);
    chk(dec_mispredict == 0, "R1", dec_mispredict, 0);
    for (int i = 0; i < ENT; i++) peek(PC_W'(i << OFS_W), INIT[1], "R1");
  endtask

  task automatic t_counter_r4();
    logic mp;
    logic [PC_W-1:0] pc = 16'h000C;
    do_branch(pc, 1, mp); do_branch(pc, 1, mp); do_branch(pc, 1, mp);
    do_branch(pc, 0, mp);
    peek(pc, 1'b1, "R4");   // 11 saturated, one decrement leaves 10
    do_branch(pc, 0, mp); do_branch(pc, 0, mp); do_branch(pc, 0, mp);
    do_branch(pc, 1, mp);
    peek(pc, 1'b0, "R4");   // 00 saturated, one increment leaves 01
  endtask

  task automatic t_hyst_r5();
    logic mp;
    logic [PC_W-1:0] pc = 16'h0014;
    do_branch(pc, 1, mp); do_branch(pc, 1, mp);
    do_branch(pc, 0, mp);
    peek(pc, 1'b1, "R5");
    do_branch(pc, 0, mp);
    peek(pc, 1'b0, "R5");
  endtask

  task automatic t_alias_r2();
    logic mp;
    do_branch(16'h3A20, 1, mp);        // index 8
    peek(16'h0023, 1'b1, "R2");        // same index, other offset/upper bits
    peek(16'h0024, mdl[9][1], "R2");   // neighbour untouched
  endtask

  task automatic t_hold_r9();
    logic [PC_W-1:0] pc = 16'h0028;    // index 10
    int k = idx_of(pc);
    logic p = mdl[k][1];
    fetch_pc = pc; fetch_valid = 1;
    edge_drive();
    ifid_hold = 1; dec_is_branch = 1; dec_taken = !p; fetch_pc = 16'h0000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(dec_mispredict == 0, "R9", dec_mispredict, 0);
      chk(dec_valid && dec_pred == p, "R9", dec_pred, p);
      edge_drive();
    end
    ifid_hold = 0;
    @(negedge clk);
    chk(dec_mispredict == 1, "R7", dec_mispredict, 1);
    mdl[k] = step(mdl[k], !p);
    edge_drive();
    dec_is_branch = 1; fetch_valid = 0;
    @(negedge clk);
    chk(dec_valid == 0, "R8", dec_valid, 0);
    chk(dec_mispredict == 0, "R8", dec_mispredict, 0);
    edge_drive();
    dec_is_branch = 0;
    peek(pc, mdl[k][1], "R9");         // updated exactly once
  endtask

  task automatic t_nonbranch_r10();
    logic [PC_W-1:0] pc = 16'h002C;    // index 11, model 01
    for (int c = 0; c < 3; c++) begin
      fetch_pc = pc; fetch_valid = 1; dec_is_branch = 0;
      edge_drive();
      fetch_valid = 0; dec_taken = 1;
      @(negedge clk);
      chk(dec_mispredict == 0, "R10", dec_mispredict, 0);
      edge_drive();
    end
    peek(pc, mdl[11][1], "R10");
  endtask

  task automatic t_same_r11();
    logic [PC_W-1:0] pc = 16'h0030;    // index 12, model 01
    fetch_pc = pc; fetch_valid = 1;
    edge_drive();
    dec_is_branch = 1; dec_taken = 1;
    @(negedge clk);
    chk(fetch_pred == 0, "R11", fetch_pred, 0);
    chk(dec_mispredict == 1, "R11", dec_mispredict, 1);
    mdl[12] = step(mdl[12], 1);
    edge_drive();
    dec_is_branch = 0;
    @(negedge clk);
    chk(dec_valid == 0, "R8", dec_valid, 0);
    chk(fetch_pred == 1, "R11", fetch_pred, 1);
    edge_drive();
    fetch_valid = 0;
  endtask

  task automatic t_loop_r12();
    logic mp;
    logic [PC_W-1:0] pc = 16'h001C;    // index 7
    int misses;
    for (int it = 0; it < 3; it++) begin
      misses = 0;
      for (int j = 0; j < 10; j++) begin
        do_branch(pc, j != 9, mp);
        misses += int'(mp);
      end
      if (it > 0) chk(misses == 1, "R12", misses, 1);
    end
  endtask

  task automatic t_rereset_r1();
    do_reset();
    peek(16'h000C, INIT[1], "R1");
    peek(16'h0030, INIT[1], "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_r1();
    t_counter_r4();
    t_hyst_r5();
    t_alias_r2();
    t_hold_r9();
    t_nonbranch_r10();
    t_same_r11();
    t_loop_r12();
    t_rereset_r1();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule